// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a programmed mode word into the stream of column addresses that a synchronous DRAM burst walks through. Controller logic loads the mode word with a one-cycle load strobe; the block validates every field, keeps the previous setting when any field holds a reserved code, and reports the decoded read latency on its own output.

A start pulse carries the first column and a write flag. From the next cycle on the block presents one column per clock, for the programmed burst length. The order is either a wrapping count or an XOR interleave inside the aligned block, and the final beat carries a last flag. A full-page burst steps through a whole 256-column row and keeps going until a stop pulse or a new start ends it. A stop pulse ends any burst early. A start pulse during a burst restarts the sequence at once.

The control is a two-state machine. In ST_IDLE nothing is emitted. The transition GO_BURST (start) enters ST_BURST. In ST_BURST the machine takes ADVANCE (next beat), RESTART (start again), END_LAST (last beat done, no start) or END_STOP (stop, no start) back to ST_IDLE.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the mode is burst length 1, sequential order, read latency 2, normal operation. A load of a valid word (length code in bits [2:0], order in bit 3, latency code in bits [6:4], operating code in bits [14:7]) replaces all fields at once.
- R2: Length codes 000, 001, 010, 011 and 111 give bursts of 1, 2, 4, 8 and 256 (full page) columns.
- R3: Latency codes 010 and 011 drive `rd_latency` to 2 and 3. The value changes on the clock edge that samples the load.
- R4: A load that holds a reserved length code (100, 101, 110), a reserved latency code (anything but 010 and 011) or an operating code other than 0x00 and 0x04 raises `mode_err` for exactly the next cycle and leaves the previous mode in place.
- R5: In sequential order (bit 3 = 0), beat k carries the low log2(BL) bits equal to (start + k) mod BL. For example, length 4 with start 2 gives 2, 3, 0, 1.
- R6: In interleaved order (bit 3 = 1), beat k carries the low log2(BL) bits equal to start XOR k. For example, length 8 with start 5 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R7: A full-page burst counts upward through the 8 low column bits and wraps within the row. It ignores the order bit, never raises `col_last`, and runs until a stop or a start.
- R8: With operating code 0x04, a start with `is_write` = 1 makes a 1-beat burst. Reads keep the programmed length.
- R9: The first column appears in the cycle after the start is sampled. One column follows per cycle, and `col_last` is high only on the final beat of a finite burst. After that beat `col_valid` falls, unless a new start arrived.
- R10: A stop sampled during a burst ends it, so `col_valid` is low in the next cycle. A start sampled in the same cycle takes precedence.
- R11: A start sampled during a burst begins the new sequence in the next cycle from the new start column.
- R12: Column bits above the burst block, and above bit 7 for a full page, equal the start column for the whole burst.
- R13: Length, order and single-write choice are captured at start. A mode load during a burst affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Load strobe for the mode word |
| mode_word | input | 15 | Mode word: length [2:0], order [3], latency [6:4], operation [14:7] |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 10 | First column of the burst |
| is_write | input | 1 | Burst belongs to a write |
| stop | input | 1 | End the current burst |
| col_valid | output | 1 | A column is presented this cycle |
| col_addr | output | 10 | Current column address |
| col_last | output | 1 | Final beat of a finite burst |
| rd_latency | output | 2 | Decoded read latency in cycles |
| mode_err | output | 1 | Previous load held a reserved code |

## Verification
The checker verifies on every cycle these rules: a start is followed by a valid column, a stop ends the stream, the last flag implies a valid beat and ends the stream, the latency stays in range and is kept on a rejected load, and the high column bits do not move within a burst. The per-beat column order for each length and order, the single-write shortening, the handling of reserved codes and the capture of the mode at start depend on the programmed history. Only the bench scenarios, compared against its reference functions, can show those.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bcs_state_e;

    typedef struct packed {
        logic [2:0] len_code;
        logic       interleave;
        logic [1:0] latency;
        logic       single_wr;
    } bcs_mode_t;

    localparam logic [2:0] LEN_FULL  = 3'b111;
    localparam logic [7:0] OP_NORMAL = 8'h00;
    localparam logic [7:0] OP_SWR    = 8'h04;

    function automatic logic len_code_ok(input logic [2:0] c);
        return (c[2] == 1'b0) || (c == LEN_FULL);
    endfunction

    function automatic logic lat_code_ok(input logic [2:0] c);
        return (c == 3'b010) || (c == 3'b011);
    endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter int MODE_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output bcs_mode_t         mode,
    output logic              err
);
    localparam int OP_LSB = 7;

    logic [2:0] w_len;
    logic       w_ilv;
    logic [2:0] w_lat;
    logic [7:0] w_op;
    logic       w_ok;

    always_comb begin
        w_len = word[2:0];
        w_ilv = word[3];
        w_lat = word[6:4];
        w_op  = word[OP_LSB +: 8];
        w_ok  = len_code_ok(w_len) && lat_code_ok(w_lat) &&
                ((w_op == OP_NORMAL) || (w_op == OP_SWR));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '{len_code: 3'b000, interleave: 1'b0, latency: 2'd2, single_wr: 1'b0};
            err  <= 1'b0;
        end else begin
            err <= load && !w_ok;
            if (load && w_ok) begin
                mode <= '{len_code: w_len, interleave: w_ilv,
                          latency: w_lat[1:0], single_wr: (w_op == OP_SWR)};
            end
        end
    end
endmodule

// File: rtl/bcs_burst_fsm.sv
module bcs_burst_fsm
    import bcs_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int BEAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             is_write,
    input  logic [COL_W-1:0] start_col,
    input  bcs_mode_t        mode,
    output logic             active,
    output logic             last,
    output logic [BEAT_W-1:0] beat,
    output logic [COL_W-1:0] base,
    output logic [2:0]       len_code,
    output logic             interleave
);
    bcs_state_e state, state_nx;
    logic [BEAT_W-1:0] beat_nx;
    logic [BEAT_W-1:0] len_m1;
    logic              full;
    logic [2:0]        cap_len;

    // length that a new burst would take, single-write shortening applied
    always_comb begin
        cap_len = (mode.single_wr && is_write) ? 3'b000 : mode.len_code;
    end

    always_comb begin
        full   = (len_code == LEN_FULL);
        len_m1 = BEAT_W'((1 << len_code[1:0]) - 1);
        last   = (state == ST_BURST) && !full && (beat == len_m1);
    end

    always_comb begin
        state_nx = state;
        beat_nx  = beat;
        unique case (state)
            ST_IDLE: begin
                if (start) begin            // GO_BURST
                    state_nx = ST_BURST;
                    beat_nx  = '0;
                end
            end
            ST_BURST: begin
                if (start) begin            // RESTART
                    beat_nx = '0;
                end else if (stop || last) begin  // END_STOP / END_LAST
                    state_nx = ST_IDLE;
                end else begin              // ADVANCE
                    beat_nx = beat + 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            beat       <= '0;
            base       <= '0;
            len_code   <= '0;
            interleave <= 1'b0;
        end else begin
            state <= state_nx;
            beat  <= beat_nx;
            if (start) begin
                base       <= start_col;
                len_code   <= cap_len;
                interleave <= mode.interleave && (cap_len != LEN_FULL);
            end
        end
    end

    always_comb begin
        active = (state == ST_BURST);
    end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
    parameter int COL_W  = 10,
    parameter int BEAT_W = 8
) (
    input  logic [COL_W-1:0]  base,
    input  logic [BEAT_W-1:0] beat,
    input  logic [2:0]        len_code,
    input  logic              interleave,
    output logic [COL_W-1:0]  addr
);
    localparam int LG_W = $clog2(BEAT_W + 1);

    logic [LG_W-1:0]  blk_bits;
    logic [COL_W-1:0] beat_ext;
    logic [COL_W-1:0] sum;

    always_comb begin
        blk_bits = (len_code == 3'b111) ? LG_W'(BEAT_W) : LG_W'(len_code[1:0]);
        beat_ext = COL_W'(beat);
        sum      = base + beat_ext;
    end

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < BEAT_W) begin : g_blk
            always_comb begin
                if (LG_W'(i) < blk_bits)
                    addr[i] = interleave ? (base[i] ^ beat[i]) : sum[i];
                else
                    addr[i] = base[i];
            end
        end else begin : g_hi
            always_comb addr[i] = base[i];
        end
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int PAGE_W = 8,
    parameter int MODE_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              is_write,
    input  logic              stop,
    output logic              col_valid,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_last,
    output logic [1:0]        rd_latency,
    output logic              mode_err
);
    bcs_mode_t         mode;
    logic              active;
    logic              last;
    logic [PAGE_W-1:0] beat;
    logic [COL_W-1:0]  base;
    logic [2:0]        len_code;
    logic              interleave;
    logic [COL_W-1:0]  addr;

    bcs_mode_reg #(.MODE_W(MODE_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .load(mode_load), .word(mode_word),
        .mode(mode), .err(mode_err)
    );

    bcs_burst_fsm #(.COL_W(COL_W), .BEAT_W(PAGE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .is_write(is_write), .start_col(start_col), .mode(mode),
        .active(active), .last(last), .beat(beat), .base(base),
        .len_code(len_code), .interleave(interleave)
    );

    bcs_addr_gen #(.COL_W(COL_W), .BEAT_W(PAGE_W)) u_addr (
        .base(base), .beat(beat), .len_code(len_code),
        .interleave(interleave), .addr(addr)
    );

    always_comb begin
        col_valid  = active;
        col_addr   = active ? addr : '0;
        col_last   = last;
        rd_latency = mode.latency;
    end
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W  = 10,
    parameter int PAGE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_load,
    input logic             start,
    input logic             stop,
    input logic             col_valid,
    input logic [COL_W-1:0] col_addr,
    input logic             col_last,
    input logic [1:0]       rd_latency,
    input logic             mode_err
);
    AST_START_GIVES_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> col_valid);  // R9
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start && col_valid) |=> !col_valid);  // R10
    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);  // R9
    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !start) |=> !col_valid);  // R9
    AST_LAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_latency == 2'd2) || (rd_latency == 2'd3));  // R3
    AST_ERR_KEEPS_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && $past(rst_n)) |=> (mode_err |-> rd_latency == $past(rd_latency)));  // R4
    AST_ERR_ONLY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load |=> !mode_err);  // R4
    AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !start) |=> (col_valid |-> col_addr[COL_W-1:PAGE_W] == $past(col_addr[COL_W-1:PAGE_W])));  // R12
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_bcs_checker (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .start(start), .stop(stop),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
    .rd_latency(rd_latency), .mode_err(mode_err)
);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [14:0] mode_word = '0;
    logic        start = 1'b0;
    logic [9:0]  start_col = '0;
    logic        is_write = 1'b0;
    logic        stop = 1'b0;
    logic        col_valid;
    logic [9:0]  col_addr;
    logic        col_last;
    logic [1:0]  rd_latency;
    logic        mode_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench copy of the programmed mode
    int m_len = 0, m_ilv = 0, m_lat = 2, m_swr = 0;

    always #4 clk = ~clk;

    burst_col_seq i_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .start(start), .start_col(start_col), .is_write(is_write), .stop(stop),
        .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
        .rd_latency(rd_latency), .mode_err(mode_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int beats_of(input int code, input int swr, input bit wr);
        if (swr != 0 && wr) return 1;
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 256;
        endcase
    endfunction

    function automatic int ref_col(input int s, input int k, input int n, input int ilv);
        int lo = s % n;
        int hi = s - lo;
        if (n == 256 || ilv == 0) return hi + ((lo + k) % n);
        return hi + (lo ^ k);
    endfunction

    function automatic bit code_valid(input int l, input int t, input int op);
        return (l <= 3 || l == 7) && (t == 2 || t == 3) && (op == 0 || op == 4);
    endfunction

    task automatic load_mode(input int l, input int ilv, input int t, input int op);
        bit ok = code_valid(l, t, op);
        @(negedge clk);
        mode_word = {op[7:0], t[2:0], ilv[0], l[2:0]};
        mode_load = 1'b1;
        @(negedge clk);
        mode_load = 1'b0;
        if (ok) begin
            m_len = l; m_ilv = ilv; m_lat = t; m_swr = (op == 4);
        end
        chk(ok ? "R1/R4 err low on valid load" : "R4 err on reserved load", int'(mode_err), ok ? 0 : 1);
        chk("R3 latency", int'(rd_latency), m_lat);
    endtask

    // runs a burst; stop_at >= 0 asserts stop during that beat
    task automatic burst(input int col, input bit wr, input int stop_at);
        int n   = beats_of(m_len, m_swr, wr);
        int ilv = m_ilv;
        int lim = (stop_at >= 0 && (stop_at < n - 1 || n == 256)) ? stop_at + 1 : n;
        @(negedge clk);
        start = 1'b1; start_col = col[9:0]; is_write = wr;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < lim; k++) begin
            chk("R9 valid during burst", int'(col_valid), 1);
            chk(n == 256 ? "R7 full page column" : (ilv != 0 ? "R6 interleaved column" : "R5 sequential column"),
                int'(col_addr), ref_col(col, k, n, ilv));
            chk(n == 256 ? "R7 no last in full page" : "R9 last flag",
                int'(col_last), (n != 256 && k == n - 1) ? 1 : 0);
            if (k == stop_at) stop = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0;
        chk(lim < n ? "R10 stop ends burst" : "R9 idle after last", int'(col_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid", int'(col_valid), 0);
        chk("R1 reset latency", int'(rd_latency), 2);
        chk("R1 reset err", int'(mode_err), 0);
        burst(37, 0, -1);                      // R1 default: one beat
        // directed corners
        load_mode(2, 0, 3, 0); burst(2, 0, -1);        // R5 2,3,0,1
        load_mode(3, 1, 2, 0); burst(5, 0, -1);        // R6 5,4,7,6,1,0,3,2
        load_mode(1, 1, 3, 0); burst(1023, 0, -1);     // R2 length 2
        load_mode(5, 0, 2, 0);                          // R4 reserved length
        load_mode(3, 0, 4, 0);                          // R4 reserved latency
        load_mode(3, 0, 2, 8);                          // R4 reserved op
        burst(6, 0, -1);                                // R4 previous mode kept
        load_mode(7, 1, 2, 0); burst(777, 0, 299);     // R7 wrap, order ignored, R12
        load_mode(3, 0, 3, 4);
        burst(9, 1, -1);                                // R8 write is single
        burst(9, 0, -1);                                // R8 read keeps length
        load_mode(3, 0, 2, 0); burst(12, 0, 3);        // R10 early stop
        // R10 start beats stop in the same cycle; R11 restart
        @(negedge clk); start = 1'b1; start_col = 10'd100; is_write = 1'b0;
        @(negedge clk); start = 1'b0;
        @(negedge clk); start = 1'b1; stop = 1'b1; start_col = 10'd203;
        @(negedge clk); start = 1'b0; stop = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk("R11 restart column", int'(col_addr), ref_col(203, k, 8, 0));
            chk("R10 start wins over stop", int'(col_valid), 1);
            @(negedge clk);
        end
        chk("R11 idle after restarted burst", int'(col_valid), 0);
        // R13 mode load in mid-burst
        @(negedge clk); start = 1'b1; start_col = 10'd19;
        @(negedge clk); start = 1'b0; mode_word = {8'h00, 3'b010, 1'b1, 3'b001}; mode_load = 1'b1;
        for (int k = 0; k < 8; k++) begin
            chk("R13 old order kept", int'(col_addr), ref_col(19, k, 8, 0));
            chk("R13 old length kept", int'(col_last), k == 7 ? 1 : 0);
            @(negedge clk); mode_load = 1'b0;
        end
        m_len = 1; m_ilv = 1; m_lat = 2; m_swr = 0;
        burst(19, 0, -1);                               // R13 new mode applies next
        // random mix
        for (int it = 0; it < 60; it++) begin
            int pick = $urandom_range(0, 9);
            int l = (pick < 5) ? pick % 4 : (pick == 5 ? 7 : (pick == 6 ? 4 + $urandom_range(0, 2) : pick % 4));
            load_mode(l, $urandom_range(0, 1), $urandom_range(1, 4), ($urandom_range(0, 3) == 0) ? 4 : 0);
            burst($urandom_range(0, 1023), $urandom_range(0, 1),
                  (m_len == 7) ? $urandom_range(0, 300) : (($urandom_range(0, 4) == 0) ? $urandom_range(0, 7) : -1));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1187));
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule